// File: doc/BRIEF.md
# Packetized Serial Scan Chain Shifter

This block loads configuration bits into one of several serial scan chains. Software writes bytes into a small write queue through three push ports, one byte, two bytes or four bytes wide. Multi-byte writes are queued lowest byte first. The engine reads the queue as a stream of packets. Each packet is a two-byte header followed by payload bytes. The engine then drives the payload bits, one per shift period, onto the data line of the single enabled chain. In the same system clock as the last cycle of each bit period, it raises a strobe on that chain.

In the header, the leading byte is a fixed command code, given by the parameter `CMD`. The trailing byte holds the payload bit count minus one, so a packet carries 1 to 128 bits. Software polls `active` and `fifo_count`, and treats the engine as idle only when the flag is low and the count is zero. Header format errors and rejected pushes are recorded in sticky flags, which only reset clears.

Top module: `scan_shift_engine`

## Requirements
- R1: When the leading header byte differs from `CMD`, the engine drops it and the byte after it, sets the sticky flag `err_cmd`, shifts no bit and returns to idle.
- R2: A count byte above 127 is rejected in the same way as in R1. A count byte of 127 shifts exactly 128 bits.
- R3: A write to `bus_addr` 1, 2 or 3 queues 1, 2 or 4 bytes, taken from `bus_wdata` starting at bits 7:0 and moving upward. A write to `bus_addr` 0 loads `chain_en` from `bus_wdata[NCH-1:0]`.
- R4: When a push does not fit entirely in the `DEPTH`-byte queue, none of its bytes are queued, `fifo_count` is unchanged and the sticky flag `err_ovf` is set.
- R5: A packet with count byte n consumes exactly ceil((n+1)/8) payload bytes. The next queued byte is parsed as a new header.
- R6: Payload bits go out least significant bit first, starting with the first payload byte. Each bit is held on `scan_data` for `DIV` clocks, and `scan_strobe` pulses on the last of those clocks. Only the enabled chain's lines ever go high.
- R7: `active` rises on the clock after the engine takes a leading header byte from the queue. It falls `DIV` clocks after the period of the last bit ends.
- R8: Writes to `bus_addr` 0 are ignored while `active` is high.
- R9: When `chain_en` is zero or has more than one bit set, the engine stays idle and takes nothing from the queue.
- R10: `fifo_count` always equals the number of queued bytes not yet taken, from 0 to `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | 0 chain enable, 1/2/3 push 1/2/4 bytes |
| bus_wdata | input | 32 | Write data |
| chain_en | output | NCH | One-hot chain enable |
| active | output | 1 | Engine busy with a packet |
| fifo_count | output | $clog2(DEPTH+1) | Queued byte count |
| err_cmd | output | 1 | Sticky bad-header flag |
| err_ovf | output | 1 | Sticky rejected-push flag |
| scan_data | output | NCH | Serial data per chain |
| scan_strobe | output | NCH | Bit-valid strobe per chain |

## Verification
Several properties are asserted on every cycle:
- the queue never exceeds its depth;
- at most one chain strobes, and only while busy;
- the enable register is frozen while busy;
- the error flags never clear;
- with an invalid enable, nothing leaves the queue.

Other behaviour only shows in the bench's scenarios, where a behavioural model is compared against the design on every clock:
- bit order across byte and packet boundaries;
- exact byte consumption;
- header rejection;
- the trailing idle period.

// File: rtl/scan_shift_engine.sv
module scan_shift_engine #(
  parameter int NCH = 4,
  parameter int DEPTH = 32,
  parameter int DIV = 4,
  parameter logic [7:0] CMD = 8'hC3,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [NCH-1:0] chain_en,
  output logic           active,
  output logic [CW-1:0]  fifo_count,
  output logic           err_cmd,
  output logic           err_ovf,
  output logic [NCH-1:0] scan_data,
  output logic [NCH-1:0] scan_strobe
);
  // DEPTH must be a power of two so the pointers wrap naturally.
  typedef enum logic [2:0] {S_IDLE, S_HDR, S_LOAD, S_SHIFT, S_TAIL} st_t;
  st_t st;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [7:0]    sh;
  logic [6:0]    left;
  logic [2:0]    bcnt;
  logic [DW-1:0] dc;
  logic          cmd_ok;
  logic          pop;

  wire [7:0] head     = mem[rp];
  wire       one_hot  = $onehot(chain_en);
  wire       tick     = dc == DW'(DIV - 1);
  wire       have     = fifo_count != '0;
  wire       push_req = bus_wr && bus_addr != 2'd0;
  wire [2:0] plen     = (bus_addr == 2'd1) ? 3'd1 : (bus_addr == 2'd2) ? 3'd2 : 3'd4;
  wire       fits     = (int'(fifo_count) + int'(plen)) <= DEPTH;
  wire       push     = push_req && fits;

  assign active      = st != S_IDLE;
  assign scan_data   = (st == S_SHIFT) ? (chain_en & {NCH{sh[0]}}) : '0;
  assign scan_strobe = (st == S_SHIFT && tick) ? chain_en : '0;

  always_comb begin
    unique case (st)
      S_IDLE:  pop = have && one_hot;
      S_HDR:   pop = have;
      S_LOAD:  pop = have;
      S_SHIFT: pop = tick && left != 7'd0 && bcnt == 3'd7 && have;
      default: pop = 1'b0;
    endcase
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    always_ff @(posedge clk)
      if (push && i < int'(plen)) mem[wp + PW'(i)] <= bus_wdata[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; fifo_count <= '0;
      err_ovf <= 1'b0; chain_en <= '0;
    end else begin
      if (push) wp <= wp + PW'(plen);
      if (pop)  rp <= rp + 1'b1;
      fifo_count <= fifo_count + (push ? CW'(plen) : CW'(0)) - CW'(pop);
      if (push_req && !fits) err_ovf <= 1'b1;
      if (bus_wr && bus_addr == 2'd0 && st == S_IDLE) chain_en <= bus_wdata[NCH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; left <= '0; bcnt <= '0; dc <= '0;
      cmd_ok <= 1'b0; err_cmd <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (pop) begin cmd_ok <= head == CMD; st <= S_HDR; end
        S_HDR: if (have) begin
          if (cmd_ok && !head[7]) begin left <= head[6:0]; st <= S_LOAD; end
          else begin err_cmd <= 1'b1; st <= S_IDLE; end
        end
        S_LOAD: if (have) begin sh <= head; bcnt <= '0; dc <= '0; st <= S_SHIFT; end
        S_SHIFT: if (tick) begin
          dc <= '0;
          if (left == 7'd0) st <= S_TAIL;
          else begin
            left <= left - 1'b1;
            bcnt <= bcnt + 1'b1;
            if (bcnt == 3'd7) begin
              if (have) sh <= head;
              else st <= S_LOAD;
            end else sh <= sh >> 1;
          end
        end else dc <= dc + 1'b1;
        S_TAIL: if (tick) begin dc <= '0; st <= S_IDLE; end
                else dc <= dc + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_count) <= DEPTH);
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(scan_strobe) && ((scan_strobe == '0) || active));
  assert_en_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) |-> $stable(chain_en));
  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_ovf) |-> err_ovf);
  assert_cmd_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_cmd) |-> err_cmd);
  assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !$onehot(chain_en)) |=> (fifo_count >= $past(fifo_count)));
endmodule

// File: tb/sim_scan_shift_engine.sv
module sim_scan_shift_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, DEPTH = 32, DIV = 4;
  localparam logic [7:0] CMD = 8'hC3;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [NCH-1:0] chain_en, scan_data, scan_strobe;
  logic active, err_cmd, err_ovf;
  logic [5:0] fifo_count;

  scan_shift_engine #(.NCH(NCH), .DEPTH(DEPTH), .DIV(DIV), .CMD(CMD)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .chain_en(chain_en), .active(active), .fifo_count(fifo_count), .err_cmd(err_cmd),
    .err_ovf(err_ovf), .scan_data(scan_data), .scan_strobe(scan_strobe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [7:0] q[$];
  int mst, mdc, mleft, mbc, sz, k, nst;
  logic [7:0] msh, h;
  logic [3:0] men;
  bit mok, merrc, merro, have, tk, pp;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); mst = 0; mdc = 0; mleft = 0; mbc = 0; msh = 0; men = 0;
      mok = 0; merrc = 0; merro = 0;
    end else begin
      sz = q.size(); have = sz > 0; h = have ? q[0] : 8'h0;
      tk = (mdc == DIV - 1); pp = 0; nst = mst;
      case (mst)
        0: if (have && $onehot(men)) begin pp = 1; mok = (h == CMD); nst = 1; end
        1: if (have) begin
             pp = 1;
             if (mok && h <= 127) begin mleft = h; nst = 2; end
             else begin merrc = 1; nst = 0; end
           end
        2: if (have) begin pp = 1; msh = h; mbc = 0; mdc = 0; nst = 3; end
        3: if (tk) begin
             mdc = 0;
             if (mleft == 0) nst = 4;
             else begin
               mleft--;
               if (mbc == 7) begin
                 if (have) begin pp = 1; msh = h; end else nst = 2;
               end else msh = msh >> 1;
               mbc = (mbc + 1) % 8;
             end
           end else mdc++;
        default: if (tk) begin mdc = 0; nst = 0; end else mdc++;
      endcase
      if (pp) void'(q.pop_front());
      if (bus_wr && bus_addr == 0 && mst == 0) men = bus_wdata[3:0];
      if (bus_wr && bus_addr != 0) begin
        k = (bus_addr == 1) ? 1 : (bus_addr == 2) ? 2 : 4;
        if (sz + k <= DEPTH) for (int i = 0; i < k; i++) q.push_back(bus_wdata[8*i +: 8]);
        else merro = 1;
      end
      mst = nst;
    end
  end

  logic cap[$];
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) if (scan_strobe[c]) cap.push_back(scan_data[c]);
      chk(fifo_count == q.size(), "R10 count", fifo_count, q.size());
      chk(active == (mst != 0), "R7 active", active, mst != 0);
      chk(chain_en == men, "R8 chain_en", chain_en, men);
      chk(err_cmd == merrc, "R1 err_cmd", err_cmd, merrc);
      chk(err_ovf == merro, "R4 err_ovf", err_ovf, merro);
      chk(scan_data == ((mst == 3) ? (men & {4{msh[0]}}) : 4'h0), "R6 data", scan_data,
          (mst == 3) ? (men & {4{msh[0]}}) : 4'h0);
      chk(scan_strobe == ((mst == 3 && mdc == DIV - 1) ? men : 4'h0), "R6 strobe", scan_strobe,
          (mst == 3 && mdc == DIV - 1) ? men : 4'h0);
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!active && fifo_count == 0) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; cap.delete();
  endtask

  logic exp_bits[$];
  task automatic add_bits(logic [7:0] b[], int n);
    for (int i = 0; i < n; i++) exp_bits.push_back(b[i/8][i%8]);
  endtask

  task automatic cmp_stream(string tag);
    chk(cap.size() == exp_bits.size(), {tag, " bit count"}, cap.size(), exp_bits.size());
    for (int i = 0; i < exp_bits.size() && i < cap.size(); i++)
      chk(cap[i] == exp_bits[i], {tag, " bit"}, cap[i], exp_bits[i]);
    cap.delete(); exp_bits.delete();
  endtask

  initial begin
    logic [7:0] pl[];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fifo_count == 0 && !active && chain_en == 0 && !err_cmd && !err_ovf,
        "R10 reset state", {active, chain_en, err_cmd, err_ovf}, 0);

    // R3 R5 R6: packets through every push width, back to back
    wr(0, 32'h2);
    wr(2, {16'h0, 8'd11, CMD});
    wr(2, 32'h0ABC);
    wr(3, {8'h5A, 8'h96, 8'd15, CMD});
    wr(1, CMD); wr(1, 32'h0); wr(1, 32'h01);
    wait_idle();
    pl = new[2]; pl[0] = 8'hBC; pl[1] = 8'h0A; add_bits(pl, 12);
    pl[0] = 8'h96; pl[1] = 8'h5A; add_bits(pl, 16);
    pl = new[1]; pl[0] = 8'h01; add_bits(pl, 1);
    cmp_stream("R6 R3 mixed ports");
    chk(fifo_count == 0, "R5 exact consumption", fifo_count, 0);

    // R2 R8: 128-bit packet, enable write while busy
    wr(0, 32'h8);
    wr(2, {16'h0, 8'd127, CMD});
    pl = new[16];
    for (int i = 0; i < 16; i++) pl[i] = 8'(i * 37 + 5);
    for (int i = 0; i < 4; i++) wr(3, {pl[4*i+3], pl[4*i+2], pl[4*i+1], pl[4*i]});
    wr(0, 32'h1);
    chk(chain_en == 4'h8, "R8 enable ignored while active", chain_en, 8);
    wait_idle();
    add_bits(pl, 128);
    cmp_stream("R2 max packet");
    repeat (2) @(negedge clk);
    chk(!active, "R7 back to idle", active, 0);

    // R1: bad command byte
    wr(2, {16'h0, 8'd3, 8'h55});
    wait_idle();
    chk(err_cmd == 1, "R1 bad header flag", err_cmd, 1);
    chk(cap.size() == 0, "R1 nothing shifted", cap.size(), 0);

    do_reset();
    wr(0, 32'h4);
    wr(2, {16'h0, 8'd200, CMD});
    wait_idle();
    chk(err_cmd == 1, "R2 oversize count flag", err_cmd, 1);
    chk(cap.size() == 0, "R2 nothing shifted", cap.size(), 0);

    // R9 R4: no enable, fill queue, overflow
    do_reset();
    for (int i = 0; i < 8; i++) wr(3, 32'h11111111 * i);
    repeat (4) @(negedge clk);
    chk(fifo_count == 32 && !active, "R9 idle without enable", fifo_count, 32);
    wr(1, 32'hEE);
    @(negedge clk);
    chk(fifo_count == 32, "R4 rejected push keeps count", fifo_count, 32);
    chk(err_ovf == 1, "R4 overflow flag", err_ovf, 1);
    wr(0, 32'h3);
    repeat (6) @(negedge clk);
    chk(fifo_count == 32 && !active, "R9 two chains enabled stays idle", fifo_count, 32);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R7 actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule